// File: doc/BRIEF.md
# Multiplane Page Striping Allocator

The allocator takes a stream of logical page numbers from a flash controller's write path. For each page it returns the physical target: a chip index, a plane index inside that chip, a physical block number, and the page offset inside that block. Software sets a geometry of 1, 2 or 4 planes per die and a power-of-two chip count. It also picks one of two placement modes.

- **Striped mode** deals consecutive pages round-robin over the planes of a chip, then over the chips. With two planes, plane 0 collects the even pages and plane 1 the odd ones. One virtual block is one physical block in every plane of every chip, and all of them carry the same block number.
- **Sequential mode** fills one block of one plane in order before it moves to the next plane, and then to the next chip.

In striped mode each result also marks the page that completes a plane-parallel batch, so the command layer can program all planes of a die together.

Both page interfaces use valid/ready handshakes.

- A page is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output holding register is empty or is being drained in the same cycle.
- The result appears one cycle after acceptance. It stays frozen while `out_valid` is high and `out_ready` is low.
- A producer may hold `in_valid` as long as it likes. The consumer may stall for any number of cycles.

The geometry can be changed only while the block is idle. A request at any other time is dropped and raises an error flag.

Top module: `mp_page_alloc`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `cfg_err` is 0. The geometry is striped mode with 2 planes and 2 chips.
- R2: In sequential mode (`cfg_mode`=0), with P planes, C chips and B pages per block:
  - the unit number u is floor(lpn/B) and the page offset is lpn mod B;
  - the plane is u mod P and the chip is floor(u/P) mod C;
  - the block is floor(u/(P*C)).
- R3: In striped mode (`cfg_mode`=1):
  - the plane is lpn mod P and the chip is floor(lpn/P) mod C;
  - with s = floor(lpn/(P*C)), the page offset is s mod B and the block is floor(s/B).
- R4: With 2 planes and 2 chips in striped mode, pages 0,1,2,3 go to (chip,plane) = (0,0),(0,1),(1,0),(1,1), and this pattern repeats every 4 pages. Chip 0 plane 0 holds pages 0,4,8,…, and the page offset steps by one every 4 pages.
- R5: In striped mode, every page with lpn in [k*P*C*B, (k+1)*P*C*B) gets block number k, whatever its chip and plane.
- R6: `out_batch_last` is 1 in sequential mode. In striped mode it is 1 exactly when `out_plane` equals P-1.
- R7: `cfg_plane_lg` encodes the plane count as 0→1, 1→2 and 2→4; the value 3 is invalid. `cfg_chip_lg` is log2 of the chip count, and values above CHIP_LOG2_MAX (default 2) are invalid. A request with an invalid value leaves the geometry unchanged and sets `cfg_err`.
- R8: The block is idle when `out_valid` and `in_valid` are both 0.
  - A `cfg_apply` pulse while the block is not idle is ignored, and `cfg_err` goes to 1 on the next edge.
  - `cfg_err` stays at 1 until a request is accepted, which clears it.
- R9: `in_ready` equals `!out_valid || out_ready`. Each accepted page yields one result, in order, valid on the cycle after acceptance. The result is held stable while `out_valid` is 1 and `out_ready` is 0.
- R10: An accepted geometry applies to every page accepted after the edge that took the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_apply | input | 1 | One-cycle request to load the geometry fields |
| cfg_mode | input | 1 | 1 = striped over planes and chips, 0 = sequential per block |
| cfg_plane_lg | input | 2 | log2 of planes per chip (0..2) |
| cfg_chip_lg | input | 3 | log2 of chip count (0..CHIP_LOG2_MAX) |
| cfg_err | output | 1 | Sticky flag for a rejected geometry request |
| in_valid | input | 1 | Logical page number is offered |
| in_ready | output | 1 | Allocator can take a page this cycle |
| in_lpn | input | LPN_W | Logical page number |
| out_valid | output | 1 | Mapped result is offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_chip | output | CHIP_W | Target chip index |
| out_plane | output | 2 | Target plane index |
| out_page | output | PPB_LOG2 | Page offset inside the physical block |
| out_block | output | LPN_W-PPB_LOG2 | Physical (and virtual) block number |
| out_batch_last | output | 1 | Result completes a plane-parallel batch |

## Verification
The bench goes after the pages that sit at block and virtual-block borders:
- the last page of one block and the first page of the next;
- lpn values that are multiples of P*C*B.

A design that takes the chip index from the wrong bits, or shifts by planes only, puts those pages in the wrong block or chip.

It also issues geometry requests while a result is stalled, and with the plane code 3 or an oversized chip count. A design that accepts those requests would map the pages that follow under the wrong geometry, and leave `cfg_err` low.

Random back-pressure together with one-cycle input gaps exposes a result that changes while stalled, a page that is dropped, and a page that is duplicated. Single-plane and four-plane geometries cover batch flags that are set too early or too late.

// File: rtl/mp_alloc_pkg.sv
package mp_alloc_pkg;

  typedef enum logic {
    PLACE_SEQ    = 1'b0,
    PLACE_STRIPE = 1'b1
  } place_mode_e;

  typedef struct packed {
    place_mode_e mode;
    logic [1:0]  plane_lg;
    logic [2:0]  chip_lg;
  } geom_t;

  localparam logic [1:0] PLANE_LG_LIMIT = 2'd2;

endpackage

// File: rtl/mp_geom_reg.sv
module mp_geom_reg
  import mp_alloc_pkg::*;
#(
  parameter int         CHIP_LOG2_MAX = 2,
  parameter logic       DEF_MODE      = 1'b1,
  parameter logic [1:0] DEF_PLANE_LG  = 2'd1,
  parameter logic [2:0] DEF_CHIP_LG   = 3'd1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  apply,
  input  geom_t req,
  input  logic  busy,
  output geom_t geom_q,
  output logic  err_q
);

  localparam logic [2:0] CHIP_LG_LIMIT = 3'(CHIP_LOG2_MAX);

  logic req_ok;
  logic take;

  assign req_ok = (req.plane_lg <= PLANE_LG_LIMIT) && (req.chip_lg <= CHIP_LG_LIMIT);
  assign take   = apply && !busy && req_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      geom_q.mode     <= place_mode_e'(DEF_MODE);
      geom_q.plane_lg <= DEF_PLANE_LG;
      geom_q.chip_lg  <= DEF_CHIP_LG;
      err_q           <= 1'b0;
    end else if (apply) begin
      if (take) begin
        geom_q <= req;
        err_q  <= 1'b0;
      end else begin
        err_q  <= 1'b1;
      end
    end
  end

  AST_CFG_BUSY_KEEP: assert property (@(posedge clk) disable iff (!rst_n) apply && busy |=> $stable(geom_q)); // R8
  AST_CFG_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n) apply && busy |=> err_q); // R8
  AST_CFG_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) apply && !req_ok |=> err_q && $stable(geom_q)); // R7
  AST_PLANE_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n) geom_q.plane_lg <= PLANE_LG_LIMIT); // R7
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) take |=> !err_q); // R8

endmodule

// File: rtl/mp_addr_map.sv
module mp_addr_map
  import mp_alloc_pkg::*;
#(
  parameter int LPN_W    = 24,
  parameter int PPB_LOG2 = 6,
  parameter int CHIP_W   = 2,
  parameter int BLK_W    = LPN_W - PPB_LOG2
) (
  input  geom_t              geom,
  input  logic [LPN_W-1:0]   lpn,
  output logic [CHIP_W-1:0]  chip,
  output logic [1:0]         plane,
  output logic [PPB_LOG2-1:0] page,
  output logic [BLK_W-1:0]   block,
  output logic               batch_last
);

  logic [LPN_W-1:0] plane_mask;
  logic [LPN_W-1:0] chip_mask;
  logic [3:0]       tgt_lg;
  logic [LPN_W-1:0] base;
  logic [LPN_W-1:0] plane_full;
  logic [LPN_W-1:0] chip_full;
  logic [LPN_W-1:0] above;
  logic [LPN_W-1:0] stripe_blk;

  assign plane_mask = (LPN_W'(1) << geom.plane_lg) - LPN_W'(1);
  assign chip_mask  = (LPN_W'(1) << geom.chip_lg) - LPN_W'(1);
  assign tgt_lg     = 4'(geom.plane_lg) + 4'(geom.chip_lg);

  // Striped mode rotates targets on the raw page number; sequential mode
  // rotates targets on the block-sized unit number.
  always_comb begin
    if (geom.mode == PLACE_STRIPE) base = lpn;
    else                           base = lpn >> PPB_LOG2;
  end

  assign plane_full = base & plane_mask;
  assign chip_full  = (base >> geom.plane_lg) & chip_mask;
  assign above      = base >> tgt_lg;
  assign stripe_blk = above >> PPB_LOG2;

  always_comb begin
    plane = plane_full[1:0];
    chip  = chip_full[CHIP_W-1:0];
    if (geom.mode == PLACE_STRIPE) begin
      page       = above[PPB_LOG2-1:0];
      block      = BLK_W'(stripe_blk);
      batch_last = (plane_full == plane_mask);
    end else begin
      page       = lpn[PPB_LOG2-1:0];
      block      = BLK_W'(above);
      batch_last = 1'b1;
    end
  end

endmodule

// File: rtl/mp_out_stage.sv
module mp_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid && in_ready |=> out_valid); // R9
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_ready && !in_valid |=> !out_valid); // R9

endmodule

// File: rtl/mp_page_alloc.sv
module mp_page_alloc
  import mp_alloc_pkg::*;
#(
  parameter int LPN_W         = 24,
  parameter int PPB_LOG2      = 6,
  parameter int CHIP_LOG2_MAX = 2,
  localparam int CHIP_W       = (CHIP_LOG2_MAX > 0) ? CHIP_LOG2_MAX : 1,
  localparam int BLK_W        = LPN_W - PPB_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_apply,
  input  logic                cfg_mode,
  input  logic [1:0]          cfg_plane_lg,
  input  logic [2:0]          cfg_chip_lg,
  output logic                cfg_err,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LPN_W-1:0]    in_lpn,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHIP_W-1:0]   out_chip,
  output logic [1:0]          out_plane,
  output logic [PPB_LOG2-1:0] out_page,
  output logic [BLK_W-1:0]    out_block,
  output logic                out_batch_last
);

  localparam int RES_W = 1 + CHIP_W + 2 + PPB_LOG2 + BLK_W;

  geom_t geom;
  geom_t geom_req;
  logic  busy;

  logic [CHIP_W-1:0]   m_chip;
  logic [1:0]          m_plane;
  logic [PPB_LOG2-1:0] m_page;
  logic [BLK_W-1:0]    m_block;
  logic                m_last;
  logic [RES_W-1:0]    res_in;
  logic [RES_W-1:0]    res_out;

  assign geom_req.mode     = place_mode_e'(cfg_mode);
  assign geom_req.plane_lg = cfg_plane_lg;
  assign geom_req.chip_lg  = cfg_chip_lg;
  assign busy              = out_valid || in_valid;

  mp_geom_reg #(
    .CHIP_LOG2_MAX(CHIP_LOG2_MAX)
  ) u_geom (
    .clk    (clk),
    .rst_n  (rst_n),
    .apply  (cfg_apply),
    .req    (geom_req),
    .busy   (busy),
    .geom_q (geom),
    .err_q  (cfg_err)
  );

  mp_addr_map #(
    .LPN_W   (LPN_W),
    .PPB_LOG2(PPB_LOG2),
    .CHIP_W  (CHIP_W),
    .BLK_W   (BLK_W)
  ) u_map (
    .geom       (geom),
    .lpn        (in_lpn),
    .chip       (m_chip),
    .plane      (m_plane),
    .page       (m_page),
    .block      (m_block),
    .batch_last (m_last)
  );

  assign res_in = {m_last, m_chip, m_plane, m_page, m_block};

  mp_out_stage #(
    .W(RES_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign {out_batch_last, out_chip, out_plane, out_page, out_block} = res_out;

  AST_SEQ_BATCH: assert property (@(posedge clk) disable iff (!rst_n) out_valid && geom.mode == PLACE_SEQ |-> out_batch_last); // R6
  AST_PLANE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (3'(out_plane) < (3'd1 << geom.plane_lg))); // R3
  AST_STRIPE_BATCH: assert property (@(posedge clk) disable iff (!rst_n) out_valid && geom.mode == PLACE_STRIPE && out_batch_last |-> (3'(out_plane) == ((3'd1 << geom.plane_lg) - 3'd1))); // R6
  AST_GEOM_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(geom)); // R8

endmodule

// File: tb/mp_page_alloc_tb.sv
module mp_page_alloc_tb;

  localparam int CLK_PERIOD    = 10;
  localparam int LPN_W         = 24;
  localparam int PPB_LOG2      = 6;
  localparam int CHIP_LOG2_MAX = 2;
  localparam int CHIP_W        = 2;
  localparam int BLK_W         = LPN_W - PPB_LOG2;
  localparam int PPB           = 1 << PPB_LOG2;
  localparam int WATCHDOG      = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_apply = 1'b0;
  logic cfg_mode = 1'b0;
  logic [1:0] cfg_plane_lg = '0;
  logic [2:0] cfg_chip_lg = '0;
  logic cfg_err;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LPN_W-1:0] in_lpn = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CHIP_W-1:0] out_chip;
  logic [1:0] out_plane;
  logic [PPB_LOG2-1:0] out_page;
  logic [BLK_W-1:0] out_block;
  logic out_batch_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_page_alloc #(
    .LPN_W(LPN_W), .PPB_LOG2(PPB_LOG2), .CHIP_LOG2_MAX(CHIP_LOG2_MAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_apply(cfg_apply), .cfg_mode(cfg_mode),
    .cfg_plane_lg(cfg_plane_lg), .cfg_chip_lg(cfg_chip_lg), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_lpn(in_lpn),
    .out_valid(out_valid), .out_ready(out_ready), .out_chip(out_chip),
    .out_plane(out_plane), .out_page(out_page), .out_block(out_block),
    .out_batch_last(out_batch_last)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  int cyc = 0;

  // model state
  int m_mode = 1, m_plg = 1, m_clg = 1;
  bit err_exp = 0;
  string err_tag = "R1";
  string phase_tag = "";
  int rdy_mode = 0;
  bit mon_en = 0;

  // scoreboard
  int sb_chip[32], sb_plane[32], sb_page[32], sb_block[32];
  bit sb_last[32];
  string sb_tag[32];
  int sb_wr = 0, sb_rd = 0;

  bit hold_prev = 0;
  longint prev_snap = 0;

  task automatic finish_test();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic longint pack_res(int c, int p, int pg, int b);
    return (longint'(c) << 48) | (longint'(p) << 40) | (longint'(pg) << 32) | longint'(b);
  endfunction

  // Expected mapping from the requirement formulas.
  task automatic push_expected(int lpn);
    int np, nc, u, s, i;
    np = 1 << m_plg;
    nc = 1 << m_clg;
    i = sb_wr % 32;
    if (m_mode == 1) begin
      sb_plane[i] = lpn % np;
      sb_chip[i]  = (lpn / np) % nc;
      s           = lpn / (np * nc);
      sb_page[i]  = s % PPB;
      sb_block[i] = s / PPB;
      sb_last[i]  = (sb_plane[i] == np - 1);
      sb_tag[i]   = (phase_tag != "") ? phase_tag : "R3";
    end else begin
      u           = lpn / PPB;
      sb_page[i]  = lpn % PPB;
      sb_plane[i] = u % np;
      sb_chip[i]  = (u / np) % nc;
      sb_block[i] = u / (np * nc);
      sb_last[i]  = 1'b1;
      sb_tag[i]   = (phase_tag != "") ? phase_tag : "R2";
    end
    sb_wr++;
  endtask

  always @(negedge clk) begin
    out_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? (($urandom % 4) != 0) : 1'b0;
  end

  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      chk(cfg_err == err_exp, err_tag, "cfg_err", longint'(cfg_err), longint'(err_exp));
      chk(in_ready == (!out_valid || out_ready), "R9", "in_ready", longint'(in_ready), longint'(!out_valid || out_ready));
      if (hold_prev) begin
        chk(out_valid == 1'b1, "R9", "valid held under stall", longint'(out_valid), 1);
        chk(pack_res(out_chip, out_plane, out_page, out_block) == prev_snap, "R9", "result held under stall",
            pack_res(out_chip, out_plane, out_page, out_block), prev_snap);
      end
      if (out_valid && out_ready) begin
        if (sb_rd == sb_wr) begin
          chk(0, "R9", "unexpected result", 1, 0);
        end else begin
          int i;
          i = sb_rd % 32;
          chk(pack_res(out_chip, out_plane, out_page, out_block) == pack_res(sb_chip[i], sb_plane[i], sb_page[i], sb_block[i]),
              sb_tag[i], "chip/plane/page/block", pack_res(out_chip, out_plane, out_page, out_block),
              pack_res(sb_chip[i], sb_plane[i], sb_page[i], sb_block[i]));
          chk(out_batch_last == sb_last[i], "R6", "batch_last", longint'(out_batch_last), longint'(sb_last[i]));
          sb_rd++;
        end
      end
      if (in_valid && in_ready) push_expected(int'(in_lpn));
      if (cfg_apply) begin
        bit idle, ok;
        idle = !in_valid && !out_valid;
        ok = (cfg_plane_lg <= 2) && (cfg_chip_lg <= 3'(CHIP_LOG2_MAX));
        if (idle && ok) begin
          m_mode = int'(cfg_mode); m_plg = int'(cfg_plane_lg); m_clg = int'(cfg_chip_lg);
          err_exp = 0; err_tag = "R10";
        end else begin
          err_exp = 1; err_tag = idle ? "R7" : "R8";
        end
      end
      hold_prev = out_valid && !out_ready;
      prev_snap = pack_res(out_chip, out_plane, out_page, out_block);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_test();
    end
  end

  task automatic send(int lpn);
    @(negedge clk);
    in_valid = 1'b1;
    in_lpn = LPN_W'(lpn);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle_cycles(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    rdy_mode = 0;
    #2;
    while (out_valid) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic pulse_cfg(int mode, int plg, int clg);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_apply = 1'b1;
    cfg_mode = mode[0];
    cfg_plane_lg = plg[1:0];
    cfg_chip_lg = clg[2:0];
    @(negedge clk);
    cfg_apply = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
    chk(cfg_err == 1'b0, "R1", "cfg_err after reset", longint'(cfg_err), 0);
    mon_en = 1;

    // R4 with the reset geometry (R1: striped, 2 planes, 2 chips)
    phase_tag = "R4";
    for (int k = 0; k < 12; k++) send(k);
    drain();

    // R5: virtual block borders, 2 planes x 2 chips
    phase_tag = "R5";
    send(255); send(256); send(257); send(511); send(512); send(515); send(1023); send(1024);
    drain();

    // R2: sequential borders, 4 planes x 1 chip
    pulse_cfg(0, 2, 0);
    phase_tag = "R2";
    send(0); send(63); send(64); send(127); send(128); send(255); send(256); send(511); send(512);
    drain();

    // R6: single plane striped, every page closes a batch
    pulse_cfg(1, 0, 2);
    phase_tag = "R6";
    for (int k = 0; k < 6; k++) send(k + 60);
    drain();

    // R7: invalid encodings while idle are refused and the geometry is kept
    pulse_cfg(0, 3, 0);
    idle_cycles(2);
    pulse_cfg(1, 1, 3);
    idle_cycles(2);
    phase_tag = "R7";
    for (int k = 0; k < 8; k++) send(k * 37);
    drain();

    // R8: request while a result is stalled is ignored
    pulse_cfg(1, 2, 1);
    phase_tag = "R8";
    @(negedge clk);
    rdy_mode = 2;
    send(9);
    pulse_cfg(0, 0, 0);
    idle_cycles(3);
    rdy_mode = 0;
    for (int k = 0; k < 8; k++) send(k + 100);
    drain();

    // random phases with back-pressure and gaps
    phase_tag = "";
    for (int ph = 0; ph < 8; ph++) begin
      pulse_cfg(int'($urandom % 2), int'($urandom % 3), int'($urandom % 3));
      rdy_mode = 1;
      for (int k = 0; k < 150; k++) begin
        send(int'($urandom & 32'h00FF_FFFF));
        if (($urandom % 4) == 0) idle_cycles(1);
      end
      drain();
    end

    idle_cycles(3);
    chk(sb_rd == sb_wr, "R9", "all accepted pages produced", longint'(sb_rd), longint'(sb_wr));
    finish_test();
  end

endmodule